// File: doc/BRIEF.md
# Costas Carrier-Tracking Loop

This block locks a local carrier phase onto a binary phase-shift keyed tone sampled at 8000 samples per second. Each accepted sample is a 12-bit offset-binary converter word. The block left-justifies it into a 16-bit two's complement value and mixes it with a sine and a cosine supplied by an external oscillator. That oscillator is addressed by the block's own 14-bit phase output. The sine product is the in-phase (I) arm and the cosine product is the quadrature (Q) arm. A decision-directed detector takes the sign of I, uses it to orient Q, and treats the result as the phase error. The error drives a leaky integrator and a proportional path. Their sum, together with a nominal increment of 3072 (1500 Hz), advances the phase modulo 16384.

A small state machine handles each sample in fixed steps. IDLE waits for a strobe. The transition named accept captures the sample and moves to MIX. MIX registers both arms, and mix_done moves to DETECT. DETECT registers the oriented error, and detect_done moves to UPDATE. UPDATE advances the integrator and phase, raises the result strobe, and update_done returns to IDLE. A downstream bit slicer reads the I arm and its sign. The sign is the recovered data symbol, up to the half-turn ambiguity that every BPSK loop has.

Top module: `costas_loop`

## Requirements
- R1: After reset the phase output, the I arm output, its sign flag and the result strobe are all zero, and the integrator starts at zero.
- R2: An accepted word w becomes the signed sample (w - 2048) * 16, which is w with its top bit inverted followed by four zero bits.
- R3: Each arm is floor(sample * reference / 32768): I uses the sine input and Q uses the cosine input. The one product equal to 2^30 (both operands -32768) gives +32767. The arms change only when a sample is mixed.
- R4: The sign flag is 1 exactly when the I arm is negative.
- R5: The phase error equals Q when I is zero or positive, and equals -Q when I is negative.
- R6: The integrator, kept with 8 fractional bits, updates once per sample: new = old - (old >>> 4) + ((error << 8) >>> 6), using arithmetic shifts.
- R7: The new phase is (old phase + (new integrator >>> 8) + (error >>> 6) + 3072) mod 16384. The phase changes only in the cycle that ends UPDATE.
- R8: The result strobe is a one-cycle pulse. It is first visible in the fourth cycle after the accepting edge. Strobes that arrive while a sample is in flight are ignored.
- R9: With a BPSK tone 5 Hz above nominal and 44 degrees off in phase, the loop settles within a few thousand samples. After settling, the mean phase error, folded for the half-turn ambiguity, stays below 500 units, and the sign of I agrees with the data (or with its inverse) on at least 95 percent of strong samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_valid | input | 1 | Strobe marking a new converter word |
| adc_word | input | 12 | Offset-binary converter word |
| nco_sin | input | 16 | Signed sine of the current phase, from the oscillator |
| nco_cos | input | 16 | Signed cosine of the current phase, from the oscillator |
| i_arm | output | 16 | Signed in-phase arm of the latest sample |
| i_neg | output | 1 | Sign of the I arm (1 = negative) |
| phase | output | 14 | Carrier phase, one turn = 16384 |
| out_valid | output | 1 | One-cycle pulse when a sample's results are ready |

## Verification
The hardest state to reach from the ports is arm saturation. It needs the most negative sample paired with a most negative reference, so a real oscillator never supplies it. The bench therefore holds the reference inputs at chosen extremes, including -32768, and sweeps every converter code against them. This also reaches large errors of both signs, which push the integrator and the phase wrap far from their settled values. Closed-loop tracking is then checked separately with the oscillator tied to the phase output and a frequency-offset BPSK tone at the input.

// File: rtl/costas_pkg.sv
package costas_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_MIX    = 2'd1,
        ST_DETECT = 2'd2,
        ST_UPDATE = 2'd3
    } state_e;

    // arm index into the mixer array
    localparam int ARM_I = 0;
    localparam int ARM_Q = 1;
    localparam int N_ARMS = 2;
endpackage

// File: rtl/costas_input_fmt.sv
module costas_input_fmt #(
    parameter int ADC_W  = 12,
    parameter int SAMP_W = 16
) (
    input  logic [ADC_W-1:0]         adc,
    output logic signed [SAMP_W-1:0] smp
);
    localparam int PAD_W = SAMP_W - ADC_W;

    // left-justify, then flip the top bit: offset binary -> two's complement
    always_comb begin
        smp = $signed({~adc[ADC_W-1], adc[ADC_W-2:0], {PAD_W{1'b0}}});
    end
endmodule

// File: rtl/costas_mixer.sv
module costas_mixer #(
    parameter int W = 16
) (
    input  logic signed [W-1:0] smp,
    input  logic signed [W-1:0] ref_val,
    output logic signed [W-1:0] arm
);
    localparam int PW = 2 * W;
    localparam logic signed [PW-1:0] OVF_PROD = $signed({2'b01, {(PW-2){1'b0}}});
    localparam logic signed [W-1:0]  ARM_MAX  = $signed({1'b0, {(W-1){1'b1}}});

    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] scaled;

    always_comb begin
        prod   = smp * ref_val;
        scaled = prod >>> (W - 1);
        if (prod == OVF_PROD) begin
            arm = ARM_MAX;
        end else begin
            arm = W'(scaled);
        end
    end
endmodule

// File: rtl/costas_loop_filter.sv
module costas_loop_filter #(
    parameter int ERR_W   = 16,
    parameter int PH_W    = 14,
    parameter int ACC_W   = 32,
    parameter int NOM_INC = 3072,
    parameter int LEAK_SH = 4,
    parameter int GAIN_SH = 6,
    parameter int PROP_SH = 6,
    parameter int FRAC_SH = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    upd_en,
    input  logic signed [ERR_W-1:0] err,
    output logic [PH_W-1:0]         phase
);
    localparam int EXT_W = ACC_W - ERR_W;
    localparam int PZ_W  = ACC_W - PH_W;

    logic signed [ACC_W-1:0] integ_q, integ_d;
    logic signed [ACC_W-1:0] err_x, corr, ph_sum;
    logic [PH_W-1:0]         phase_q, phase_d;

    always_comb begin
        err_x   = $signed({{EXT_W{err[ERR_W-1]}}, err});
        integ_d = integ_q - (integ_q >>> LEAK_SH) + ((err_x <<< FRAC_SH) >>> GAIN_SH);
        corr    = (integ_d >>> FRAC_SH) + (err_x >>> PROP_SH);
        ph_sum  = $signed({{PZ_W{1'b0}}, phase_q}) + corr + ACC_W'(NOM_INC);
        phase_d = PH_W'(ph_sum);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            integ_q <= '0;
            phase_q <= '0;
        end else if (upd_en) begin
            integ_q <= integ_d;
            phase_q <= phase_d;
        end
    end

    assign phase = phase_q;
endmodule

// File: rtl/costas_loop.sv
module costas_loop #(
    parameter int ADC_W   = 12,
    parameter int SAMP_W  = 16,
    parameter int PH_W    = 14,
    parameter int ACC_W   = 32,
    parameter int NOM_INC = 3072,
    parameter int LEAK_SH = 4,
    parameter int GAIN_SH = 6,
    parameter int PROP_SH = 6,
    parameter int FRAC_SH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_valid,
    input  logic [ADC_W-1:0]  adc_word,
    input  logic [SAMP_W-1:0] nco_sin,
    input  logic [SAMP_W-1:0] nco_cos,
    output logic [SAMP_W-1:0] i_arm,
    output logic              i_neg,
    output logic [PH_W-1:0]   phase,
    output logic              out_valid
);
    import costas_pkg::*;

    state_e state_q, state_d;

    logic take_smp, do_mix, do_det, do_upd;

    logic signed [SAMP_W-1:0] smp_fmt, smp_q;
    logic signed [SAMP_W-1:0] nco_ref [N_ARMS];
    logic signed [SAMP_W-1:0] arm_raw [N_ARMS];
    logic signed [SAMP_W-1:0] arm_q   [N_ARMS];
    logic signed [SAMP_W-1:0] err_d, err_q;
    logic                     valid_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (sample_valid) state_d = ST_MIX;   // accept
            ST_MIX:    state_d = ST_DETECT;                  // mix_done
            ST_DETECT: state_d = ST_UPDATE;                  // detect_done
            ST_UPDATE: state_d = ST_IDLE;                    // update_done
            default:   state_d = ST_IDLE;
        endcase
    end

    // per-state stage enables
    always_comb begin
        take_smp = 1'b0;
        do_mix   = 1'b0;
        do_det   = 1'b0;
        do_upd   = 1'b0;
        unique case (state_q)
            ST_IDLE:   take_smp = sample_valid;
            ST_MIX:    do_mix   = 1'b1;
            ST_DETECT: do_det   = 1'b1;
            ST_UPDATE: do_upd   = 1'b1;
            default:   ;
        endcase
    end

    costas_input_fmt #(
        .ADC_W (ADC_W),
        .SAMP_W(SAMP_W)
    ) u_fmt (
        .adc(adc_word),
        .smp(smp_fmt)
    );

    assign nco_ref[ARM_I] = $signed(nco_sin);
    assign nco_ref[ARM_Q] = $signed(nco_cos);

    for (genvar g = 0; g < N_ARMS; g++) begin : g_arm
        costas_mixer #(.W(SAMP_W)) u_mix (
            .smp    (smp_q),
            .ref_val(nco_ref[g]),
            .arm    (arm_raw[g])
        );

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                arm_q[g] <= '0;
            end else if (do_mix) begin
                arm_q[g] <= arm_raw[g];
            end
        end
    end

    // decision-directed detector: orient Q by the sign of I
    always_comb begin
        if (arm_q[ARM_I][SAMP_W-1]) begin
            err_d = -arm_q[ARM_Q];
        end else begin
            err_d = arm_q[ARM_Q];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_q   <= '0;
            err_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            if (take_smp) smp_q <= smp_fmt;
            if (do_det)   err_q <= err_d;
            valid_q <= do_upd;
        end
    end

    costas_loop_filter #(
        .ERR_W  (SAMP_W),
        .PH_W   (PH_W),
        .ACC_W  (ACC_W),
        .NOM_INC(NOM_INC),
        .LEAK_SH(LEAK_SH),
        .GAIN_SH(GAIN_SH),
        .PROP_SH(PROP_SH),
        .FRAC_SH(FRAC_SH)
    ) u_filt (
        .clk   (clk),
        .rst_n (rst_n),
        .upd_en(do_upd),
        .err   (err_q),
        .phase (phase)
    );

    assign i_arm     = arm_q[ARM_I];
    assign i_neg     = arm_q[ARM_I][SAMP_W-1];
    assign out_valid = valid_q;
endmodule

// File: rtl/costas_loop_chk.sv
module costas_loop_chk #(
    parameter int SAMP_W = 16,
    parameter int PH_W   = 14
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 sample_valid,
    input logic                 out_valid,
    input logic [SAMP_W-1:0]    i_arm,
    input logic [PH_W-1:0]      phase,
    input costas_pkg::state_e   state
);
    import costas_pkg::*;

    // R8
    accept_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && sample_valid) |=> (state == ST_MIX));

    // R8
    busy_mix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MIX) |=> (state == ST_DETECT));

    // R8
    busy_detect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DETECT) |=> (state == ST_UPDATE));

    // R8
    result_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_UPDATE) |=> (out_valid && state == ST_IDLE));

    // R8
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R7
    phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_UPDATE) |=> $stable(phase));

    // R3
    arm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_MIX) |=> $stable(i_arm));
endmodule

bind costas_loop costas_loop_chk #(
    .SAMP_W(SAMP_W),
    .PH_W  (PH_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample_valid(sample_valid),
    .out_valid   (out_valid),
    .i_arm       (i_arm),
    .phase       (phase),
    .state       (state_q)
);

// File: tb/costas_loop_tb.sv
`timescale 1ns/1ps
module costas_loop_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_valid = 1'b0;
    logic [11:0] adc_word = '0;
    logic [15:0] nco_sin, nco_cos;
    logic [15:0] i_arm;
    logic        i_neg;
    logic [13:0] phase;
    logic        out_valid;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;
    bit loop_mode = 1'b0;
    logic [15:0] f_sin = '0, f_cos = '0;

    int m_integ = 0;
    int m_phase = 0;

    always #2.5 clk = ~clk;

    costas_loop u_dut (
        .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .adc_word(adc_word),
        .nco_sin(nco_sin), .nco_cos(nco_cos), .i_arm(i_arm), .i_neg(i_neg),
        .phase(phase), .out_valid(out_valid)
    );

    function automatic logic [15:0] sin_q(input int p);
        real a;
        a = 6.283185307179586 * real'(p) / 16384.0;
        return 16'($rtoi(32767.0 * $sin(a)));
    endfunction

    always_comb begin
        if (loop_mode) begin
            nco_sin = sin_q(int'(phase));
            nco_cos = sin_q((int'(phase) + 4096) % 16384);
        end else begin
            nco_sin = f_sin;
            nco_cos = f_cos;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int conv(input logic [11:0] w);
        return (int'(w) - 2048) * 16;
    endfunction

    function automatic int arm_of(input int s, input int r);
        int p;
        p = s * r;
        if (p == (1 << 30)) return 32767;
        return p >>> 15;
    endfunction

    // one sample through the DUT and the reference model
    task automatic run_sample(input logic [11:0] w, input bit poke, output int i_out);
        int sv, cv, s, iv, qv, e, lat;
        @(negedge clk);
        sample_valid = 1'b1;
        adc_word = w;
        sv = int'($signed(nco_sin));
        cv = int'($signed(nco_cos));
        @(negedge clk);
        if (poke) adc_word = ~w; else sample_valid = 1'b0;
        lat = 1;
        while (!out_valid && lat < 20) begin
            @(negedge clk);
            lat++;
            if (lat == 3) sample_valid = 1'b0;
        end
        s  = conv(w);
        iv = arm_of(s, sv);
        qv = arm_of(s, cv);
        e  = (iv < 0) ? -qv : qv;
        m_integ = m_integ - (m_integ >>> 4) + ((e <<< 8) >>> 6);
        m_phase = (m_phase + (m_integ >>> 8) + (e >>> 6) + 3072) & 16383;
        chk("R8 latency", lat, 4);
        chk("R2/R3 i_arm", int'($signed(i_arm)), iv);
        chk("R4 i_neg", int'(i_neg), (iv < 0) ? 1 : 0);
        chk("R5/R6/R7 phase", int'(phase), m_phase);
        @(negedge clk);
        chk("R8 pulse", int'(out_valid), 0);
        i_out = iv;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        sample_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_integ = 0;
        m_phase = 0;
        @(negedge clk);
        chk("R1 phase", int'(phase), 0);
        chk("R1 i_arm", int'(i_arm), 0);
        chk("R1 i_neg", int'(i_neg), 0);
        chk("R1 out_valid", int'(out_valid), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        int iv;
        do_reset();

        // R2 R3 R5 R6 R7: all codes against fixed references, saturation corner included
        for (int p = 0; p < 3; p++) begin
            case (p)
                0: begin f_sin = 16'sh8000; f_cos = 16'sh7FFF; end
                1: begin f_sin = 16'sd23170; f_cos = 16'sh8000; end
                default: begin f_sin = 16'sh7FFF; f_cos = 16'sd12345; end
            endcase
            for (int c = 0; c < 4096; c++) begin
                run_sample(12'(c), (c % 97) == 5, iv);
            end
        end
        // R3 saturation explicitly: word 0 is sample -32768
        f_sin = 16'sh8000;
        f_cos = 16'sh8000;
        run_sample(12'd0, 1'b0, iv);
        chk("R3 saturate", iv, 32767);

        // R9 closed loop with offset BPSK tone
        do_reset();
        loop_mode = 1'b1;
        begin
            int theta, d, w, ph_used, dd, f, sum_f, agree, disagree, best;
            logic [15:0] lfsr;
            theta = 2000;
            lfsr = 16'hACE1;
            d = 1;
            sum_f = 0;
            agree = 0;
            disagree = 0;
            for (int k = 0; k < 4000; k++) begin
                if (k % 10 == 0) begin
                    d = lfsr[0] ? 1 : -1;
                    lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
                end
                w = 2048 + $rtoi(1500.0 * real'(d) *
                        $sin(6.283185307179586 * real'(theta) / 16384.0));
                ph_used = int'(phase);
                run_sample(12'(w), 1'b0, iv);
                if (k >= 3000) begin
                    dd = (ph_used - theta + 32768) % 16384;
                    f = dd % 8192;
                    if (f > 4096) f = 8192 - f;
                    sum_f += f;
                end
                if (k >= 2000 && (iv > 2000 || iv < -2000)) begin
                    if ((iv < 0) == (d < 0)) agree++; else disagree++;
                end
                theta = (theta + 3082) % 16384;
            end
            chk("R9 mean phase error below 500", (sum_f / 1000 < 500) ? 1 : 0, 1);
            if (sum_f / 1000 >= 500) $display("  mean folded error %0d", sum_f / 1000);
            best = (agree > disagree) ? agree : disagree;
            chk("R9 sign follows data", (best * 100 >= 95 * (agree + disagree) && best > 100) ? 1 : 0, 1);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule